// File: doc/BRIEF.md
# Video Status Register with Vertical-Blank Interrupt

This block is the status-register side of a tile-based video controller. It runs on the pixel clock and keeps two flags: a vertical-blank flag, set at a fixed scanline/dot position, and a sprite-zero-hit flag, set when an opaque sprite-0 pixel lands on an opaque background pixel. It drives an active-low non-maskable interrupt toward the CPU, gated by an enable bit. The scanline/dot position comes in from the video timing logic. A CPU read of the status register arrives as a one-pixel-clock strobe. The CPU runs at one third of the pixel clock, so a read lands on any one of three pixel-clock phases.

The block reproduces the race between a status read and the setting of the vertical-blank flag. A read on the same pixel clock as the set returns the flag clear, and the flag and the interrupt are lost for that frame. A read one or two pixel clocks later returns the flag set, but the interrupt is still lost for that frame. The interrupt pin only becomes visible once the flag has been set for an arming delay of `NMI_DLY` pixel clocks, so a read inside that window acknowledges the flag before the CPU could have seen the interrupt. A per-frame suppress latch holds the loss until the pre-render line.

Top module: `vstat_core`

## Requirements
- R1: While reset is asserted, `rd_data` is 0 and `nmi_n` is 1.
- R2: The status byte is {vblank, sprite-zero-hit, 6'b0}: bit 7 is the vertical-blank flag, bit 6 is sprite-zero hit, and bits 5:0 read 0. The vertical-blank flag reads 1 from the cycle after the position (`VBL_LINE`, `VBL_DOT`) is presented, unless a read is made in that cycle.
- R3: `rd_data` always shows the current flags. A cycle with `rd_stb` high clears the vertical-blank flag from the next cycle on.
- R4: A read in the cycle where the set position is presented returns bit 7 = 0. After it, the flag stays 0 and `nmi_n` stays 1 for the rest of that frame.
- R5: A read made 1 or 2 cycles after the set-position cycle returns bit 7 = 1, and `nmi_n` stays 1 for that whole frame.
- R6: A read made 3 or more cycles after the set-position cycle returns bit 7 = 1, and `nmi_n` was 0 in at least one cycle of that frame.
- R7: With no read, `nmi_n` is 0 exactly when the flag has been set for at least `NMI_DLY` (2) cycles and `nmi_en` is 1. It first goes low 3 cycles after the set-position cycle. Raising `nmi_en` later in vertical blank pulls it low in the same cycle.
- R8: Sprite-zero hit reads 1 in the cycle after `bg_opaque` and `spr0_opaque` are both 1. `spr0_opaque` alone does not set it.
- R9: Sprite-zero hit never pulls `nmi_n` low, and a status read does not clear it.
- R10: The cycle after the pre-render position (`PRE_LINE`, `CLR_DOT`), both flags read 0 and suppression is released, so the next frame's interrupt fires normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line | input | LINE_W | Current scanline |
| dot | input | DOT_W | Current dot within the scanline |
| rd_stb | input | 1 | Status read, one pixel clock wide |
| nmi_en | input | 1 | Interrupt enable |
| bg_opaque | input | 1 | Background pixel at this dot is opaque |
| spr0_opaque | input | 1 | Sprite-0 pixel at this dot is opaque |
| rd_data | output | 8 | Status byte |
| nmi_n | output | 1 | Active-low interrupt request |

## Verification
The main pattern moves one status read across the start of vertical blank, one pixel clock later each frame, from three cycles before the set to five cycles after. Each offset is checked against its expected pair of interrupt-seen and bit-7-read results. This separates four cases: a read before the set, a read on the set cycle (both lost), reads in the arming window (flag seen, interrupt lost) and late reads (both seen). Frames with no read fix the exact cycle in which the interrupt asserts, and show that enabling the interrupt late in vertical blank raises it at once. A no-read frame placed after a suppressed frame shows that the pre-render line releases the suppression. Sprite-zero hit is tried with the sprite pixel opaque alone and with both pixels opaque, and then through a status read, to show that the hit needs both pixels, survives the read and never touches the interrupt.

// File: rtl/vstat_core.sv
module vstat_core #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int VBL_DOT  = 1,
  parameter int PRE_LINE = 261,
  parameter int CLR_DOT  = 1,
  parameter int NMI_DLY  = 2,
  localparam int LINE_W  = $clog2(LINES),
  localparam int DOT_W   = $clog2(DOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic              rd_stb,
  input  logic              nmi_en,
  input  logic              bg_opaque,
  input  logic              spr0_opaque,
  output logic [7:0]        rd_data,
  output logic              nmi_n
);

  localparam int AGE_W = $clog2(NMI_DLY + 1);

  logic             vb, hit, sup;
  logic [AGE_W-1:0] age;
  logic             set_pos, clr_pos, armed;

  assign set_pos = (line == LINE_W'(VBL_LINE)) && (dot == DOT_W'(VBL_DOT));
  assign clr_pos = (line == LINE_W'(PRE_LINE)) && (dot == DOT_W'(CLR_DOT));
  assign armed   = (age == AGE_W'(NMI_DLY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb  <= 1'b0;
      hit <= 1'b0;
      sup <= 1'b0;
      age <= '0;
    end else if (clr_pos) begin
      vb  <= 1'b0;
      hit <= 1'b0;
      sup <= 1'b0;
      age <= '0;
    end else begin
      if (set_pos && !rd_stb) vb <= 1'b1;
      else if (rd_stb)        vb <= 1'b0;

      if (set_pos)             age <= '0;
      else if (vb && !armed)   age <= age + 1'b1;

      if (rd_stb && (set_pos || (vb && !armed))) sup <= 1'b1;

      if (bg_opaque && spr0_opaque) hit <= 1'b1;
    end
  end

  assign rd_data = {vb, hit, 6'b0};
  assign nmi_n   = !(vb && nmi_en && armed && !sup);

endmodule

// File: rtl/vstat_core_chk.sv
module vstat_core_chk #(
  parameter int LINE_W   = 9,
  parameter int DOT_W    = 9,
  parameter int VBL_LINE = 241,
  parameter int VBL_DOT  = 1,
  parameter int PRE_LINE = 261,
  parameter int CLR_DOT  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line,
  input logic [DOT_W-1:0]  dot,
  input logic              rd_stb,
  input logic              nmi_en,
  input logic              bg_opaque,
  input logic              spr0_opaque,
  input logic [7:0]        rd_data,
  input logic              nmi_n
);

  logic at_set, at_clr;
  assign at_set = (line == LINE_W'(VBL_LINE)) && (dot == DOT_W'(VBL_DOT));
  assign at_clr = (line == LINE_W'(PRE_LINE)) && (dot == DOT_W'(CLR_DOT));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (rd_data == 8'h00 && nmi_n);
    end
  end

  p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:0] == 6'b0);

  p_flag_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (at_set && !rd_stb) |=> rd_data[7]);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_data[7]);

  p_race_loses_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_set && rd_stb) |=> (!rd_data[7] && nmi_n));

  p_nmi_after_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> (rd_data[7] && nmi_en && $past(rd_data[7]) && $past(rd_data[7], 2)));

  p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_opaque && spr0_opaque && !at_clr) |=> rd_data[6]);

  p_hit_kept_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_data[6] && !at_clr) |=> rd_data[6]);

  p_prerender_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    at_clr |=> (rd_data[7:6] == 2'b00 && nmi_n));

endmodule

bind vstat_core vstat_core_chk #(
  .LINE_W(LINE_W), .DOT_W(DOT_W), .VBL_LINE(VBL_LINE), .VBL_DOT(VBL_DOT),
  .PRE_LINE(PRE_LINE), .CLR_DOT(CLR_DOT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .line(line), .dot(dot), .rd_stb(rd_stb),
  .nmi_en(nmi_en), .bg_opaque(bg_opaque), .spr0_opaque(spr0_opaque),
  .rd_data(rd_data), .nmi_n(nmi_n)
);

// File: tb/vstat_core_tb_top.sv
`timescale 1ns/1ps
module vstat_core_tb_top;

  localparam int DOTS = 16, LINES = 8, VBL_LINE = 5, VBL_DOT = 1;
  localparam int PRE_LINE = 7, CLR_DOT = 1;
  localparam int FRAME = DOTS * LINES;
  localparam int S = VBL_LINE * DOTS + VBL_DOT;
  localparam int C = PRE_LINE * DOTS + CLR_DOT;
  localparam int LW = $clog2(LINES), DW = $clog2(DOTS);

  localparam int NV = 9;
  localparam int OFS   [NV] = '{-3, -2, -1, 0, 1, 2, 3, 4, 5};
  localparam bit EXP_N [NV] = '{1, 1, 1, 0, 0, 0, 1, 1, 1};
  localparam bit EXP_V [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_stb = 1'b0, nmi_en = 1'b0, bg_opaque = 1'b0, spr0_opaque = 1'b0;
  logic [7:0] rd_data;
  logic nmi_n;
  int p;
  logic [LW-1:0] line;
  logic [DW-1:0] dot;
  int checks = 0, errors = 0;
  bit nmi_seen;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) p <= 0;
    else        p <= (p == FRAME - 1) ? 0 : p + 1;

  assign line = LW'(p / DOTS);
  assign dot  = DW'(p % DOTS);

  vstat_core #(
    .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE), .VBL_DOT(VBL_DOT),
    .PRE_LINE(PRE_LINE), .CLR_DOT(CLR_DOT), .NMI_DLY(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .line(line), .dot(dot), .rd_stb(rd_stb),
    .nmi_en(nmi_en), .bg_opaque(bg_opaque), .spr0_opaque(spr0_opaque),
    .rd_data(rd_data), .nmi_n(nmi_n)
  );

  always @(negedge clk) if (rst_n && !nmi_n) nmi_seen = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int t);
    @(negedge clk);
    while (p != t) @(negedge clk);
    #1;
  endtask

  function automatic string req_of(input int k);
    if (k == 0) return "R4";
    if (k == 1 || k == 2) return "R5";
    return "R6";
  endfunction

  task automatic quiet_frame_nmi(input string req);
    wait_pos(S + 2);
    check(nmi_n == 1'b1, req, nmi_n, 1);
    wait_pos(S + 3);
    check(nmi_n == 1'b0, req, nmi_n, 0);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit v;
    repeat (3) @(negedge clk);
    #1;
    check(rd_data == 8'h00, "R1 status", rd_data, 0);
    check(nmi_n == 1'b1, "R1 nmi", nmi_n, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // frame 0: sprite-zero hit, then late enable
    wait_pos(20);
    spr0_opaque = 1'b1;
    wait_pos(21);
    spr0_opaque = 1'b0;
    check(rd_data[6] == 1'b0, "R8 sprite alone", rd_data[6], 0);
    bg_opaque = 1'b1; spr0_opaque = 1'b1;
    wait_pos(22);
    bg_opaque = 1'b0; spr0_opaque = 1'b0;
    check(rd_data[6] == 1'b1, "R8 both opaque", rd_data[6], 1);
    check(rd_data[5:0] == 6'b0, "R2 low bits", rd_data[5:0], 0);
    rd_stb = 1'b1;
    wait_pos(23);
    rd_stb = 1'b0;
    check(rd_data[6] == 1'b1, "R9 hit kept", rd_data[6], 1);
    check(nmi_n == 1'b1, "R9 hit no nmi", nmi_n, 1);
    wait_pos(S + 1);
    check(rd_data[7] == 1'b1, "R2 flag set", rd_data[7], 1);
    wait_pos(S + 4);
    check(nmi_n == 1'b1, "R7 disabled", nmi_n, 1);
    nmi_en = 1'b1;
    #1;
    check(nmi_n == 1'b0, "R7 late enable", nmi_n, 0);
    wait_pos(C + 1);
    check(rd_data == 8'h00, "R10 flags cleared", rd_data, 0);
    check(nmi_n == 1'b1, "R10 nmi released", nmi_n, 1);

    // frame 1: no read, exact assertion cycle
    quiet_frame_nmi("R7");

    // sweep of read offset across the set position
    for (int i = 0; i < NV; i++) begin
      wait_pos(0);
      nmi_seen = 1'b0;
      wait_pos(S + OFS[i]);
      rd_stb = 1'b1;
      v = rd_data[7];
      wait_pos(S + OFS[i] + 1);
      rd_stb = 1'b0;
      check(v == EXP_V[i], req_of(OFS[i]), v, EXP_V[i]);
      check(rd_data[7] == 1'b0, "R3 read clears", rd_data[7], 0);
      wait_pos(FRAME - 1);
      check(nmi_seen == EXP_N[i], req_of(OFS[i]), nmi_seen, EXP_N[i]);
    end

    // suppressed frame followed by a normal one
    wait_pos(S);
    rd_stb = 1'b1;
    wait_pos(S + 1);
    rd_stb = 1'b0;
    wait_pos(S + 10);
    check(rd_data[7] == 1'b0, "R4 flag stays clear", rd_data[7], 0);
    quiet_frame_nmi("R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule